// File: doc/BRIEF.md
# Extended Configuration Byte Switch Executor

This block is the card-side executor of the switch command. The command changes one byte of a 512-byte extended configuration register. A 32-bit argument arrives together with a one-cycle strobe. The block splits the argument into a reserved-bit check, an access mode, a target byte index, a value byte and a command-set selector. It then either updates the addressed byte in place or changes the active command set. Only three bytes are writable: erase-group definition (index 175), bus width (index 183) and high-speed timing (index 185). Every other byte reads back a fixed value. The card-type byte (index 196) comes from a parameter, and all remaining bytes read as zero.

An accepted switch opens a busy window of `BUSY_CYCLES` cycles, and switch strobes that arrive inside it are dropped. A rejected switch changes nothing, opens no busy window and raises the switch-error flag. That flag is the one reported at bit 7 of the card status word. A read-only byte port lets the surrounding logic fetch any register byte at any time.

Top module: `extcsd_switch`

## Requirements
- R1: After reset, `busy`, `done` and `switchError` are 0, and `cmdSet` is 3'b001. Bytes 175, 183 and 185 read as their init parameters (all 0 by default), byte 196 reads as `CARD_TYPE_INIT` (0x03 by default), and every other index reads 0.
- R2: The argument fields are: [25:24] access mode, [23:16] target index, [15:8] value byte, [2:0] command set. Access mode 1 ORs the value byte into the target byte.
- R3: Access mode 2 clears each target-byte bit whose value-byte bit is 1.
- R4: Access mode 3 replaces the target byte with the value byte.
- R5: Access mode 0 loads `cmdSet` from argument [2:0] when that field is exactly one of 3'b001, 3'b010 or 3'b100, and leaves all bytes unchanged. Any other command-set value is rejected.
- R6: A switch with any 1 in argument bits [31:26] or [7:3] is rejected.
- R7: In modes 1 to 3, a target index other than 175, 183 or 185 is rejected. This covers read-only bytes such as 196.
- R8: A mode 1 to 3 update of byte 183 whose result is not 0, 1, 2, 5 or 6 is rejected.
- R9: A rejected switch leaves all bytes and `cmdSet` unchanged and does not assert `busy`.
- R10: Each processed strobe gives a one-cycle `done` pulse in the next cycle. At that edge, `switchError` becomes 1 for a rejection and 0 for an acceptance, and it holds until the next processed strobe.
- R11: After an accepted switch, `busy` is high for exactly `BUSY_CYCLES` cycles, starting with the cycle of `done`. A strobe while `busy` is high is ignored: it produces no `done` and changes no byte or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| argValid | input | 1 | One-cycle strobe: a switch argument is present |
| argWord | input | 32 | Switch command argument |
| rdIndex | input | 9 | Byte index for the read port |
| rdData | output | 8 | Register byte at `rdIndex` (combinational) |
| done | output | 1 | Pulse: a strobe was processed |
| switchError | output | 1 | Result of the last processed strobe: 1 = rejected |
| busy | output | 1 | Busy window after an accepted switch |
| cmdSet | output | 3 | Active one-hot command set |

## Verification
The bench drives illegal bus-width results in each update mode: a write of 3, and a clear that leaves 4. A design that checked only the value byte, and not the resulting byte, would accept the clear and leave the card in an undefined bus mode. It also drives writes to the read-only card-type byte, reserved-bit violations at both ends of the argument, and command-set fields that are empty or carry two bits. A design that filtered only some of these would corrupt state or report no error. A strobe placed inside the busy window catches a design that queues or executes it. The bench also counts the exact length of the busy window, which exposes off-by-one counter loads.

// File: rtl/extcsd_sw_pkg.sv
package extcsd_sw_pkg;

  localparam int WR_COUNT = 3;
  localparam int SLOT_W   = 2;
  localparam int SLOT_BW  = 1;

  localparam logic [7:0] IDX_CARD_TYPE = 8'd196;

  typedef enum logic [1:0] {
    MODE_CMDSET  = 2'd0,
    MODE_SETBITS = 2'd1,
    MODE_CLRBITS = 2'd2,
    MODE_WRITE   = 2'd3
  } accessMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic              wrEn;
    logic [SLOT_W-1:0] slot;
    logic [7:0]        wrData;
  } dpCtrl_t;

  // Register index of each writable storage slot
  function automatic logic [7:0] slotIndex(input int s);
    case (s)
      0:       slotIndex = 8'd175;
      1:       slotIndex = 8'd183;
      default: slotIndex = 8'd185;
    endcase
  endfunction

  function automatic logic legalBusWidth(input logic [7:0] v);
    legalBusWidth = (v == 8'd0) || (v == 8'd1) || (v == 8'd2) ||
                    (v == 8'd5) || (v == 8'd6);
  endfunction

endpackage

// File: rtl/extcsd_sw_data.sv
module extcsd_sw_data
  import extcsd_sw_pkg::*;
#(
  parameter logic [7:0] ERASE_GRP_INIT = 8'h00,
  parameter logic [7:0] BUS_WIDTH_INIT = 8'h00,
  parameter logic [7:0] HS_TIMING_INIT = 8'h00,
  parameter logic [7:0] CARD_TYPE_INIT = 8'h03
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic [SLOT_W-1:0] targetSlot,
  output logic [7:0]        curByte,
  input  logic [8:0]        rdIndex,
  output logic [7:0]        rdData
);

  logic [WR_COUNT-1:0][7:0] wrBytes;

  function automatic logic [7:0] initFor(input int s);
    case (s)
      0:       initFor = ERASE_GRP_INIT;
      1:       initFor = BUS_WIDTH_INIT;
      default: initFor = HS_TIMING_INIT;
    endcase
  endfunction

  for (genvar g = 0; g < WR_COUNT; g++) begin : gSlot
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (!rstN)
        q <= initFor(g);
      else if (ctl.wrEn && (ctl.slot == SLOT_W'(g)))
        q <= ctl.wrData;
    end
    assign wrBytes[g] = q;
  end

  always_comb begin
    curByte = 8'h00;
    for (int s = 0; s < WR_COUNT; s++)
      if (targetSlot == SLOT_W'(s)) curByte = wrBytes[s];
  end

  always_comb begin
    rdData = 8'h00;
    if (rdIndex == {1'b0, IDX_CARD_TYPE}) rdData = CARD_TYPE_INIT;
    for (int s = 0; s < WR_COUNT; s++)
      if (rdIndex == {1'b0, slotIndex(s)}) rdData = wrBytes[s];
  end

endmodule

// File: rtl/extcsd_sw_ctl.sv
module extcsd_sw_ctl
  import extcsd_sw_pkg::*;
#(
  parameter int BUSY_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              argValid,
  input  logic [31:0]       argWord,
  input  logic [7:0]        curByte,
  output logic [SLOT_W-1:0] targetSlot,
  output dpCtrl_t           ctl,
  output logic              done,
  output logic              switchError,
  output logic              busy,
  output logic [2:0]        cmdSet
);

  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0] busyCnt;
  accessMode_e      mode;
  logic [7:0]       tgtIdx, valByte, newByte;
  logic [2:0]       csField;
  logic             rsvdBad, slotHit, csOk, argOk, take;

  assign mode    = accessMode_e'(argWord[25:24]);
  assign tgtIdx  = argWord[23:16];
  assign valByte = argWord[15:8];
  assign csField = argWord[2:0];
  assign rsvdBad = (|argWord[31:26]) || (|argWord[7:3]);
  assign csOk    = (csField == 3'b001) || (csField == 3'b010) || (csField == 3'b100);

  always_comb begin
    slotHit    = 1'b0;
    targetSlot = '0;
    for (int s = 0; s < WR_COUNT; s++)
      if (tgtIdx == slotIndex(s)) begin
        slotHit    = 1'b1;
        targetSlot = SLOT_W'(s);
      end
  end

  always_comb begin
    case (mode)
      MODE_SETBITS: newByte = curByte | valByte;
      MODE_CLRBITS: newByte = curByte & ~valByte;
      MODE_WRITE:   newByte = valByte;
      default:      newByte = curByte;
    endcase
  end

  always_comb begin
    if (rsvdBad)
      argOk = 1'b0;
    else if (mode == MODE_CMDSET)
      argOk = csOk;
    else
      argOk = slotHit &&
              !((targetSlot == SLOT_W'(SLOT_BW)) && !legalBusWidth(newByte));
  end

  assign take = argValid && (busyCnt == '0);
  assign busy = (busyCnt != '0);

  always_comb begin
    ctl.wrEn   = take && argOk && (mode != MODE_CMDSET);
    ctl.slot   = targetSlot;
    ctl.wrData = newByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCnt     <= '0;
      done        <= 1'b0;
      switchError <= 1'b0;
      cmdSet      <= 3'b001;
    end else begin
      done <= take;
      if (take) begin
        switchError <= !argOk;
        if (argOk) begin
          busyCnt <= CNT_W'(BUSY_CYCLES);
          if (mode == MODE_CMDSET) cmdSet <= csField;
        end
      end else if (busyCnt != '0) begin
        busyCnt <= busyCnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/extcsd_switch.sv
module extcsd_switch
  import extcsd_sw_pkg::*;
#(
  parameter int         BUSY_CYCLES    = 8,
  parameter logic [7:0] ERASE_GRP_INIT = 8'h00,
  parameter logic [7:0] BUS_WIDTH_INIT = 8'h00,
  parameter logic [7:0] HS_TIMING_INIT = 8'h00,
  parameter logic [7:0] CARD_TYPE_INIT = 8'h03
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        argValid,
  input  logic [31:0] argWord,
  input  logic [8:0]  rdIndex,
  output logic [7:0]  rdData,
  output logic        done,
  output logic        switchError,
  output logic        busy,
  output logic [2:0]  cmdSet
);

  dpCtrl_t           ctl;
  logic [SLOT_W-1:0] targetSlot;
  logic [7:0]        curByte;

  extcsd_sw_ctl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctl (
    .clk(clk), .rstN(rstN), .argValid(argValid), .argWord(argWord),
    .curByte(curByte), .targetSlot(targetSlot), .ctl(ctl),
    .done(done), .switchError(switchError), .busy(busy), .cmdSet(cmdSet)
  );

  extcsd_sw_data #(
    .ERASE_GRP_INIT(ERASE_GRP_INIT), .BUS_WIDTH_INIT(BUS_WIDTH_INIT),
    .HS_TIMING_INIT(HS_TIMING_INIT), .CARD_TYPE_INIT(CARD_TYPE_INIT)
  ) u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .targetSlot(targetSlot),
    .curByte(curByte), .rdIndex(rdIndex), .rdData(rdData)
  );

endmodule

// File: rtl/extcsd_switch_chk.sv
module extcsd_switch_chk (
  input logic       clk,
  input logic       rstN,
  input logic       argValid,
  input logic       done,
  input logic       switchError,
  input logic       busy,
  input logic [2:0] cmdSet,
  input logic [8:0] rdIndex,
  input logic [7:0] rdData
);

  p_accept_opens_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    (done && !switchError) |-> busy);

  p_reject_no_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (done && switchError) |-> !busy);

  p_strobe_in_busy_dropped_r11: assert property (@(posedge clk) disable iff (!rstN)
    (argValid && busy) |=> !done);

  p_error_held_r10: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(switchError));

  p_cmdset_held_r5: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(cmdSet));

  p_cmdset_onehot_r5: assert property (@(posedge clk) disable iff (!rstN)
    $countones(cmdSet) == 1);

  p_bytes_held_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!done && $stable(rdIndex)) |-> $stable(rdData));

endmodule

bind extcsd_switch extcsd_switch_chk u_chk (
  .clk(clk), .rstN(rstN), .argValid(argValid), .done(done),
  .switchError(switchError), .busy(busy), .cmdSet(cmdSet),
  .rdIndex(rdIndex), .rdData(rdData)
);

// File: tb/extcsd_switch_test.sv
module extcsd_switch_test;

  localparam int BUSY = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        argValid = 1'b0;
  logic [31:0] argWord = '0;
  logic [8:0]  rdIndex = '0;
  logic [7:0]  rdData;
  logic        done, switchError, busy;
  logic [2:0]  cmdSet;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  typedef struct { logic err; logic [2:0] cs; string tag; } expItem_t;
  expItem_t sb[$];

  logic [7:0] mEg = 8'h00, mBw = 8'h00, mHs = 8'h00;
  logic [2:0] mCs = 3'b001;

  always #10 clk = ~clk;

  extcsd_switch #(.BUSY_CYCLES(BUSY)) uut (
    .clk(clk), .rstN(rstN), .argValid(argValid), .argWord(argWord),
    .rdIndex(rdIndex), .rdData(rdData), .done(done),
    .switchError(switchError), .busy(busy), .cmdSet(cmdSet)
  );

  function automatic logic [31:0] mk(input logic [1:0] m, input logic [7:0] idx,
                                     input logic [7:0] v, input logic [2:0] cs);
    return {6'b0, m, idx, v, 5'b0, cs};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Bench model built from the requirements
  task automatic model(input logic [31:0] a, output logic ok);
    logic [1:0] m;
    logic [7:0] idx, v, cur, nb;
    logic [2:0] cs;
    m = a[25:24]; idx = a[23:16]; v = a[15:8]; cs = a[2:0];
    ok = 1'b1;
    if (a[31:26] != 0 || a[7:3] != 0) ok = 1'b0;
    if (m == 2'd0) begin
      if (!(cs == 3'b001 || cs == 3'b010 || cs == 3'b100)) ok = 1'b0;
      if (ok) mCs = cs;
    end else begin
      if (idx == 8'd175) cur = mEg;
      else if (idx == 8'd183) cur = mBw;
      else if (idx == 8'd185) cur = mHs;
      else begin cur = 8'h00; ok = 1'b0; end
      nb = (m == 2'd1) ? (cur | v) : (m == 2'd2) ? (cur & ~v) : v;
      if (idx == 8'd183 && !(nb == 0 || nb == 1 || nb == 2 || nb == 5 || nb == 6)) ok = 1'b0;
      if (ok) begin
        if (idx == 8'd175) mEg = nb;
        else if (idx == 8'd183) mBw = nb;
        else mHs = nb;
      end
    end
  endtask

  // Driver: pushes expected item, strobes for one cycle
  task automatic issue(input logic [31:0] a, input bit ignored, input string tag,
                       output logic ok);
    expItem_t it;
    ok = 1'b0;
    if (!ignored) begin
      model(a, ok);
      it.err = !ok; it.cs = mCs; it.tag = tag;
      sb.push_back(it);
    end
    @(negedge clk);
    argValid = 1'b1; argWord = a;
    @(negedge clk);
    argValid = 1'b0; argWord = '0;
  endtask

  // Monitor: compare each done against the scoreboard
  always @(negedge clk) begin
    if (rstN && done) begin
      if (sb.size() == 0) begin
        tests++; fails++;
        $display("FAIL R11: unexpected done, actual 1 expected 0");
      end else begin
        expItem_t it;
        it = sb.pop_front();
        chk({it.tag, " switchError R10"}, 32'(switchError), 32'(it.err));
        chk({it.tag, " cmdSet R5"}, 32'(cmdSet), 32'(it.cs));
      end
    end
  end

  task automatic rd(input logic [8:0] idx, input logic [7:0] exp, input string tag);
    rdIndex = idx;
    #1;
    chk(tag, 32'(rdData), 32'(exp));
  endtask

  task automatic busyLen(input string tag);
    int cnt = 0;
    while (busy && cnt < 50) begin cnt++; @(negedge clk); end
    chk(tag, cnt, BUSY);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    logic ok;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 switchError", 32'(switchError), 0);
    chk("R1 cmdSet", 32'(cmdSet), 1);
    rd(9'd175, 8'h00, "R1 byte175");
    rd(9'd183, 8'h00, "R1 byte183");
    rd(9'd185, 8'h00, "R1 byte185");
    rd(9'd196, 8'h03, "R1 byte196");
    rd(9'd10,  8'h00, "R1 byte10");
    rd(9'd300, 8'h00, "R1 byte300");

    // R4 write byte + R11 busy length
    issue(mk(2'd3, 8'd185, 8'h01, 3'd1), 0, "R4 write185", ok);
    busyLen("R11 busy length");
    rd(9'd185, 8'h01, "R4 byte185");

    // R2 / R3 set and clear bits
    issue(mk(2'd3, 8'd175, 8'hA0, 3'd0), 0, "R4 write175", ok); busyLen("R11 busy");
    issue(mk(2'd1, 8'd175, 8'h05, 3'd0), 0, "R2 or175", ok);    busyLen("R11 busy");
    rd(9'd175, 8'hA5, "R2 byte175");
    issue(mk(2'd2, 8'd175, 8'h21, 3'd0), 0, "R3 clr175", ok);   busyLen("R11 busy");
    rd(9'd175, 8'h84, "R3 byte175");

    // R8 bus width legality
    issue(mk(2'd3, 8'd183, 8'h02, 3'd0), 0, "R8 bw=2", ok); busyLen("R11 busy");
    issue(mk(2'd3, 8'd183, 8'h03, 3'd0), 0, "R8 bw=3", ok);
    chk("R9 no busy after reject", 32'(busy), 0);
    rd(9'd183, 8'h02, "R8 byte183 kept");
    issue(mk(2'd1, 8'd183, 8'h04, 3'd0), 0, "R8 bw|4", ok); busyLen("R11 busy");
    rd(9'd183, 8'h06, "R8 byte183=6");
    issue(mk(2'd2, 8'd183, 8'h02, 3'd0), 0, "R8 bw clr->4", ok);
    rd(9'd183, 8'h06, "R8 byte183 kept");

    // R6 reserved bits
    issue(mk(2'd3, 8'd185, 8'h07, 3'd0) | 32'h8000_0000, 0, "R6 bit31", ok);
    issue(mk(2'd3, 8'd185, 8'h07, 3'd0) | 32'h0000_0008, 0, "R6 bit3", ok);
    rd(9'd185, 8'h01, "R6 byte185 kept");

    // R7 read-only / unlisted index
    issue(mk(2'd3, 8'd196, 8'h00, 3'd0), 0, "R7 write196", ok);
    rd(9'd196, 8'h03, "R7 byte196 kept");
    issue(mk(2'd1, 8'd10, 8'hFF, 3'd0), 0, "R7 or10", ok);
    rd(9'd10, 8'h00, "R7 byte10 kept");

    // R5 command set
    issue(mk(2'd0, 8'd175, 8'hFF, 3'b010), 0, "R5 cs=2", ok); busyLen("R11 busy");
    rd(9'd175, 8'h84, "R5 bytes untouched");
    issue(mk(2'd0, 8'd0, 8'h00, 3'b011), 0, "R5 cs=3", ok);
    issue(mk(2'd0, 8'd0, 8'h00, 3'b000), 0, "R5 cs=0", ok);
    chk("R5 cmdSet kept", 32'(cmdSet), 2);

    // R10 error cleared by next acceptance
    issue(mk(2'd3, 8'd185, 8'h00, 3'd0), 0, "R10 clear err", ok);
    chk("R10 switchError cleared", 32'(switchError), 0);

    // R11 strobe during busy ignored
    issue(mk(2'd3, 8'd185, 8'hFF, 3'd0), 1, "R11 ignored", ok);
    while (busy) @(negedge clk);
    rd(9'd185, 8'h00, "R11 byte185 kept");
    chk("R11 switchError kept", 32'(switchError), 0);

    repeat (3) @(negedge clk);
    chk("scoreboard drained", sb.size(), 0);
    finish();
  end

endmodule